// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator with Per-Line Bypass

This block sits between a set of up to 32 peripheral interrupt sources and a parent interrupt controller. Each connected source is a level signal. Software sees two 32-bit words over a small register bus. The first is a read/write enable word. The second is a read-only status word that shows the current level of every connected source. Enabled, pending sources are ORed into one or more grouped parent outputs. A build-time map mask for each output picks which lines belong to it.

Some lines have a routing gate, selected by a build-time forward mask. A line whose forward bit is set skips the enable logic and all grouped outputs. It drives its own dedicated parent output bit, which copies the source level with one register of delay, so the parent sees that line as if this block were not there. A line whose forward bit is clear takes the grouped, enable-gated path. Bit positions outside the build-time connection mask have no source. They read as zero and never drive an output. There is no set or clear shortcut, so software changes the enable word by reading it, modifying it and writing the whole word back.

The bus side is a two-state machine. In BUS_IDLE a presented request is accepted. This always leads to BUS_RESP, where the response is valid for exactly one cycle. BUS_RESP then always returns to BUS_IDLE. A request presented while the machine is in BUS_RESP is dropped.

Top module: `intc_l2_aggregator`

## Requirements
- R1: After reset the enable word is zero, `resp_valid` is low, and every bit of `grp_irq` and `fwd_irq` is low.
- R2: A write accepted at word address 0 stores the full data word into the enable word, with unconnected positions forced to zero. A read at address 0 returns the stored word.
- R3: A read at word address 1 returns the source levels ANDed with the connection mask, as sampled in the accept cycle. A write to address 1, 2 or 3 leaves the enable word unchanged. A read at address 2 or 3 returns zero.
- R4: In each cycle, `grp_irq[g]` equals the OR, over the previous cycle, of source AND enable AND connection mask AND map mask `g` AND NOT forward mask. It drops one cycle after the contributing sources go low.
- R5: In each cycle, `fwd_irq[i]` equals the previous cycle's `src_irq[i]` for a connected line whose forward bit is set, whatever the enable word holds. It is zero for every other line.
- R6: A forwarded line never raises any `grp_irq` bit, even when that line is enabled and its map bit is set.
- R7: A source at an unconnected position never raises any output bit, and it reads as zero in the status word.
- R8: A request accepted in BUS_IDLE raises `resp_valid` for exactly the next cycle. A request presented while `resp_valid` is high is ignored, and it has no effect on the enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 32 | Level interrupt sources, one per bit position |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Word address: 0 enable, 1 status, 2 and 3 unused |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | 32 | Read data, valid while `resp_valid` is high |
| grp_irq | output | NUM_GROUPS | Grouped, enable-gated parent outputs |
| fwd_irq | output | 32 | Dedicated bypass outputs, one per line position |

## Verification
The bench tries each of the 32 single-bit source patterns twice, once with every line enabled and once with none enabled. This separates lines in each map group, forwarded lines and unconnected lines, one at a time. A long series of arithmetically generated source and enable words then mixes lines across groups, so an OR-reduction fault or a wrong mask shows up where single bits cannot expose it. Directed sequences cover the remaining corners: a request during the response cycle, writes to read-only addresses, reads of unused addresses, and a source dropping while it is enabled.

// File: rtl/intc_l2_pkg.sv
package intc_l2_pkg;

    localparam int LINE_W = 32;
    localparam int ADDR_W = 2;

    typedef logic [LINE_W-1:0] line_vec_t;
    typedef logic [ADDR_W-1:0] word_addr_t;

    localparam word_addr_t ADDR_ENABLE = 2'd0;
    localparam word_addr_t ADDR_STATUS = 2'd1;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_t;

endpackage

// File: rtl/intc_regbank.sv
module intc_regbank
    import intc_l2_pkg::*;
#(
    parameter line_vec_t CONN_MASK = 32'h0000_0FFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  word_addr_t req_addr,
    input  line_vec_t  req_wdata,
    input  line_vec_t  status_lvl,
    output logic       resp_valid,
    output line_vec_t  resp_rdata,
    output line_vec_t  enable_q
);

    bus_state_t state_q;
    bus_state_t state_d;
    line_vec_t  rdata_q;
    line_vec_t  rd_mux;
    logic       accept;

    assign accept = (state_q == BUS_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req_valid) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // read selection
    always_comb begin
        rd_mux = '0;
        unique case (req_addr)
            ADDR_ENABLE: rd_mux = enable_q;
            ADDR_STATUS: rd_mux = status_lvl;
            default:     rd_mux = '0;
        endcase
    end

    // enable word and captured read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            rdata_q  <= '0;
        end else if (accept) begin
            if (req_write) begin
                rdata_q <= '0;
                if (req_addr == ADDR_ENABLE) begin
                    enable_q <= req_wdata & CONN_MASK;
                end
            end else begin
                rdata_q <= rd_mux;
            end
        end
    end

    // outputs
    always_comb begin
        resp_valid = (state_q == BUS_RESP);
        resp_rdata = rdata_q;
    end

    assert_resp_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> resp_valid);

    assert_resp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_drop_in_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> $stable(enable_q));

    assert_status_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write && (req_addr != ADDR_ENABLE)) |=> $stable(enable_q));

endmodule

// File: rtl/intc_group_or.sv
module intc_group_or
    import intc_l2_pkg::*;
#(
    parameter int                          NUM_GROUPS = 2,
    parameter logic [NUM_GROUPS*LINE_W-1:0] MAP_MASKS  = {32'h0000_0140, 32'h0000_0EB8},
    parameter line_vec_t                   FWD_MASK   = 32'h0000_0007,
    parameter line_vec_t                   CONN_MASK  = 32'h0000_0FFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  line_vec_t             src_lvl,
    input  line_vec_t             enable,
    output logic [NUM_GROUPS-1:0] grp_irq
);

    localparam line_vec_t GATED_LINES = CONN_MASK & ~FWD_MASK;

    line_vec_t live_terms;
    assign live_terms = src_lvl & enable & GATED_LINES;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam line_vec_t THIS_MAP = MAP_MASKS[g*LINE_W +: LINE_W];
        logic hit;
        assign hit = |(live_terms & THIS_MAP);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                grp_irq[g] <= 1'b0;
            end else begin
                grp_irq[g] <= hit;
            end
        end
    end

    assert_quiet_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) == '0) |-> (grp_irq == '0));

    assert_fwd_excluded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_lvl & ~FWD_MASK) == '0) |-> (grp_irq == '0));

endmodule

// File: rtl/intc_fwd_path.sv
module intc_fwd_path
    import intc_l2_pkg::*;
#(
    parameter line_vec_t FWD_MASK  = 32'h0000_0007,
    parameter line_vec_t CONN_MASK = 32'h0000_0FFF
) (
    input  logic      clk,
    input  logic      rst_n,
    input  line_vec_t src_lvl,
    output line_vec_t fwd_irq
);

    localparam line_vec_t PASS_LINES = FWD_MASK & CONN_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_irq <= '0;
        end else begin
            fwd_irq <= src_lvl & PASS_LINES;
        end
    end

endmodule

// File: rtl/intc_l2_aggregator.sv
module intc_l2_aggregator
    import intc_l2_pkg::*;
#(
    parameter int                           NUM_GROUPS = 2,
    parameter logic [NUM_GROUPS*32-1:0]     MAP_MASKS  = {32'h0000_0140, 32'h0000_0EB8},
    parameter logic [31:0]                  FWD_MASK   = 32'h0000_0007,
    parameter logic [31:0]                  CONN_MASK  = 32'h0000_0FFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [31:0]           src_irq,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [1:0]            req_addr,
    input  logic [31:0]           req_wdata,
    output logic                  resp_valid,
    output logic [31:0]           resp_rdata,
    output logic [NUM_GROUPS-1:0] grp_irq,
    output logic [31:0]           fwd_irq
);

    line_vec_t status_lvl;
    line_vec_t enable_q;

    assign status_lvl = src_irq & CONN_MASK;

    intc_regbank #(
        .CONN_MASK (CONN_MASK)
    ) u_regbank (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .status_lvl (status_lvl),
        .resp_valid (resp_valid),
        .resp_rdata (resp_rdata),
        .enable_q   (enable_q)
    );

    intc_group_or #(
        .NUM_GROUPS (NUM_GROUPS),
        .MAP_MASKS  (MAP_MASKS),
        .FWD_MASK   (FWD_MASK),
        .CONN_MASK  (CONN_MASK)
    ) u_group (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_lvl (status_lvl),
        .enable  (enable_q),
        .grp_irq (grp_irq)
    );

    intc_fwd_path #(
        .FWD_MASK  (FWD_MASK),
        .CONN_MASK (CONN_MASK)
    ) u_fwd (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_lvl (src_irq),
        .fwd_irq (fwd_irq)
    );

    // one cycle after reset the output registers reflect sampled inputs
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_fwd_transparent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (fwd_irq == ($past(src_irq) & FWD_MASK & CONN_MASK)));

    assert_unconn_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ($past(src_irq & CONN_MASK) == '0)) |-> ((grp_irq == '0) && (fwd_irq == '0)));

endmodule

// File: tb/test_intc_l2_aggregator.sv
module test_intc_l2_aggregator;

    localparam int          NG   = 2;
    localparam logic [63:0] MAPS = {32'h0000_0140, 32'h0000_0EBF};
    localparam logic [31:0] FWD  = 32'h0000_0005;
    localparam logic [31:0] CONN = 32'h0000_0FFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   src_irq = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          resp_valid;
    logic [31:0]   resp_rdata;
    logic [NG-1:0] grp_irq;
    logic [31:0]   fwd_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    intc_l2_aggregator #(
        .NUM_GROUPS (NG),
        .MAP_MASKS  (MAPS),
        .FWD_MASK   (FWD),
        .CONN_MASK  (CONN)
    ) i_intc_l2_aggregator (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_irq    (src_irq),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .resp_valid (resp_valid),
        .resp_rdata (resp_rdata),
        .grp_irq    (grp_irq),
        .fwd_irq    (fwd_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [NG-1:0] model_grp(input logic [31:0] s, input logic [31:0] e);
        logic [NG-1:0] r;
        for (int g = 0; g < NG; g++) begin
            r[g] = |(s & e & CONN & ~FWD & MAPS[g*32 +: 32]);
        end
        return r;
    endfunction

    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic bus(input bit wr, input logic [1:0] a, input logic [31:0] d,
                       output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        check("R8", {31'd0, resp_valid}, 32'd1, "response strobe after accept");
        rd = resp_rdata;
        req_valid = 1'b0;
        @(negedge clk);
        check("R8", {31'd0, resp_valid}, 32'd0, "response strobe lasts one cycle");
    endtask

    // program enable, apply source, check outputs and both words
    task automatic pattern(input logic [31:0] s, input logic [31:0] e, input string tag);
        logic [31:0] rd;
        bus(1'b1, 2'd0, e, rd);
        @(negedge clk);
        src_irq = s;
        @(negedge clk);
        check(tag, {{(32-NG){1'b0}}, grp_irq}, {{(32-NG){1'b0}}, model_grp(s, e & CONN)},
              "grouped outputs");
        check("R5", fwd_irq, s & FWD & CONN, "forward outputs");
        bus(1'b0, 2'd1, 32'd0, rd);
        check("R3", rd, s & CONN, "status word");
        bus(1'b0, 2'd0, 32'd0, rd);
        check("R2", rd, e & CONN, "enable readback");
    endtask

    initial begin
        logic [31:0] rd;
        logic [31:0] seed;
        string tag;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {31'd0, resp_valid}, 32'd0, "resp_valid after reset");
        check("R1", {{(32-NG){1'b0}}, grp_irq}, 32'd0, "grp_irq after reset");
        check("R1", fwd_irq, 32'd0, "fwd_irq after reset");
        bus(1'b0, 2'd0, 32'd0, rd);
        check("R1", rd, 32'd0, "enable word after reset");

        // single-line sweeps, all enabled and none enabled
        for (int i = 0; i < 32; i++) begin
            if (!CONN[i])     tag = "R7";
            else if (FWD[i])  tag = "R6";
            else              tag = "R4";
            pattern(32'd1 << i, 32'hFFFF_FFFF, tag);
            pattern(32'd1 << i, 32'h0000_0000, tag);
        end

        // mixed patterns
        seed = 32'h1234_5678;
        for (int k = 0; k < 150; k++) begin
            logic [31:0] s;
            logic [31:0] e;
            seed = xs(seed);
            s = seed;
            seed = xs(seed);
            e = seed;
            pattern(s, e, "R4");
        end

        // R4 level behaviour: enabled grouped line drops one cycle after source
        pattern(32'h0000_0002, 32'hFFFF_FFFF, "R4");
        @(negedge clk);
        src_irq = 32'h0;
        @(negedge clk);
        check("R4", {{(32-NG){1'b0}}, grp_irq}, 32'd0, "grouped output after source drop");

        // R8 request during response is dropped
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 2'd0; req_wdata = 32'h0000_0AAA;
        @(negedge clk);
        check("R8", {31'd0, resp_valid}, 32'd1, "first write answered");
        req_wdata = 32'h0000_0555;
        @(negedge clk);
        check("R8", {31'd0, resp_valid}, 32'd0, "request in response cycle not accepted");
        req_valid = 1'b0;
        @(negedge clk);
        bus(1'b0, 2'd0, 32'd0, rd);
        check("R8", rd, 32'h0000_0AAA, "enable keeps first write");

        // R3 writes to read-only and unused addresses are ignored
        bus(1'b1, 2'd1, 32'hFFFF_FFFF, rd);
        bus(1'b1, 2'd2, 32'h0000_0123, rd);
        bus(1'b1, 2'd3, 32'h0000_0321, rd);
        bus(1'b0, 2'd0, 32'd0, rd);
        check("R3", rd, 32'h0000_0AAA, "enable unchanged by other writes");
        src_irq = 32'hFFFF_FFFF;
        bus(1'b0, 2'd2, 32'd0, rd);
        check("R3", rd, 32'd0, "unused address 2 reads zero");
        bus(1'b0, 2'd3, 32'd0, rd);
        check("R3", rd, 32'd0, "unused address 3 reads zero");
        bus(1'b0, 2'd1, 32'd0, rd);
        check("R7", rd, CONN, "unconnected bits read zero");
        check("R7", fwd_irq & ~CONN, 32'd0, "no output from unconnected lines");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule